// File: doc/BRIEF.md
# SIMD Rounding Accumulating Right Shifter

This block is the execution datapath for vector shift-right-by-immediate operations. It takes a decoded instruction field, one source vector and one destination vector. Each lane of the source is shifted right by an immediate amount, either logically or arithmetically. The block can round the shifted value, add it into the matching destination lane, or do both.

The lane width and the shift amount both come from a packed 7-bit immediate. The vector is 64 or 128 bits wide, and lanes are 8, 16, 32 or 64 bits. Encodings that do not belong to the group raise a flag instead of producing a result. The result is registered and appears one cycle after an input pulse, together with a valid strobe. Saturating and narrowing shifts are not handled here. Fixed-point conversions and register storage belong to the surrounding pipeline.

Top module: `simd_rshift_acc`

## Requirements
- R1: The lane width comes from the highest set bit of `immh`. Bit 3 set gives 64-bit lanes, bit 2 as the top set bit gives 32, bit 1 gives 16, and `immh` = 0001 gives 8.
- R2: The shift amount is twice the lane width minus the unsigned 7-bit value `{immh, immb}`, with `immh` as the high part. The amount always lies between 1 and the lane width.
- R3: Opcode 0x00 writes the shifted source lane. `is_unsigned` = 1 selects a logical shift and 0 selects an arithmetic shift.
- R4: Opcode 0x04 adds 1 << (shift-1) to the source lane before the shift. The sum is kept one bit wider than the lane, so a carry out of the lane's top bit appears in the result. For example, an 8-bit 0xFF rounded and shifted by 1 gives 0x80.
- R5: In signed rounding, including 64-bit lanes, the source is sign-extended before the rounding add. For example, 64-bit -1 rounded and shifted by 64 gives 0.
- R6: A shift equal to the lane width gives 0 for unsigned lanes. For signed lanes it gives every bit equal to the source sign bit, before any rounding or accumulation.
- R7: Opcode 0x02 adds the shifted value into the destination lane, and opcode 0x06 adds the rounded shifted value. The sum wraps modulo 2^lane width.
- R8: With `q_full` = 0 only the low 64 bits are computed, and result bits 127:64 are 0.
- R9: `immh` bit 3 set while `q_full` = 0 is unallocated. `unalloc` is 1 and `result` keeps its previous value.
- R10: `immh` = 0000 is unallocated. `unalloc` is 1 and `result` keeps its previous value.
- R11: Any opcode other than 0x00, 0x02, 0x04 and 0x06 is unallocated. `unalloc` is 1 and `result` keeps its previous value.
- R12: `out_valid` is 1 exactly in the cycle after each cycle with `in_valid` = 1, and `result` and `unalloc` are valid then. After reset `result` is 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| q_full | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| is_unsigned | input | 1 | 1: logical shift, 0: arithmetic shift |
| immh | input | 4 | Immediate high part (lane width and shift) |
| immb | input | 3 | Immediate low part (shift) |
| opcode | input | 5 | Operation variant |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Destination vector for accumulation |
| out_valid | output | 1 | Result strobe |
| unalloc | output | 1 | Unallocated encoding flag |
| result | output | 128 | Result vector |

## Verification
A wrong lane-width decode shows on the very next strobe. The damage spreads across lane boundaries in the result: carries or sign bits cross into a neighbouring lane, or bits are missing from it. A rounding sum that is too narrow loses the carry only when a lane's top bits are all ones, so all-ones and most-negative sources are driven directly rather than left to random values. A bad hold on unallocated encodings shows as a changed `result` in the same strobe as `unalloc`. A stuck or spurious strobe shows one cycle after the input.

// File: rtl/simd_shr_pkg.sv
package simd_shr_pkg;
  typedef enum logic [1:0] {LANE8 = 2'd0, LANE16 = 2'd1, LANE32 = 2'd2, LANE64 = 2'd3} lane_size_e;

  localparam logic [4:0] OP_PLAIN  = 5'h00;
  localparam logic [4:0] OP_ACC    = 5'h02;
  localparam logic [4:0] OP_RND    = 5'h04;
  localparam logic [4:0] OP_RNDACC = 5'h06;

  typedef struct packed {
    logic       unalloc;
    lane_size_e size;
    logic [6:0] shamt;
    logic       rnd;
    logic       acc;
  } shr_ctrl_t;

  function automatic lane_size_e size_from_immh(input logic [3:0] immh);
    if (immh[3])      return LANE64;
    else if (immh[2]) return LANE32;
    else if (immh[1]) return LANE16;
    else              return LANE8;
  endfunction

  function automatic logic [6:0] shift_from_imm(input lane_size_e sz,
                                                input logic [3:0] immh,
                                                input logic [2:0] immb);
    logic [7:0] twice_w;
    logic [7:0] diff;
    twice_w = 8'd16 << sz;
    diff    = twice_w - {1'b0, immh, immb};
    return diff[6:0];
  endfunction
endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import simd_shr_pkg::*;
(
  input  logic       q_full,
  input  logic [3:0] immh,
  input  logic [2:0] immb,
  input  logic [4:0] opcode,
  output shr_ctrl_t  ctrl
);
  logic op_known;

  always_comb begin
    op_known = (opcode == OP_PLAIN) || (opcode == OP_ACC) ||
               (opcode == OP_RND)   || (opcode == OP_RNDACC);
    ctrl.size    = size_from_immh(immh);
    ctrl.shamt   = shift_from_imm(ctrl.size, immh, immb);
    ctrl.rnd     = opcode[2];
    ctrl.acc     = opcode[1];
    ctrl.unalloc = (immh == 4'd0) || (immh[3] && !q_full) || !op_known;
  end
endmodule

// File: rtl/shr_lane.sv
module shr_lane #(
  parameter int W  = 8,
  localparam int SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  dst,
  input  logic [SW-1:0] shamt,
  input  logic          is_unsigned,
  input  logic          do_round,
  input  logic          do_acc,
  output logic [W-1:0]  res
);
  logic [W:0]   wide_src;
  logic [W:0]   round_k;
  logic [W:0]   wide_sum;
  logic [W:0]   shifted;

  always_comb begin
    wide_src = {(is_unsigned ? 1'b0 : src[W-1]), src};
    round_k  = do_round ? ({{W{1'b0}}, 1'b1} << (shamt - 1'b1)) : '0;
    wide_sum = wide_src + round_k;
    if (is_unsigned) shifted = wide_sum >> shamt;
    else             shifted = $signed(wide_sum) >>> shamt;
    res = shifted[W-1:0] + (do_acc ? dst : '0);
  end
endmodule

// File: rtl/simd_rshift_acc.sv
module simd_rshift_acc
  import simd_shr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             q_full,
  input  logic             is_unsigned,
  input  logic [3:0]       immh,
  input  logic [2:0]       immb,
  input  logic [4:0]       opcode,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_vec,
  output logic             out_valid,
  output logic             unalloc,
  output logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NKIND  = 4;

  shr_ctrl_t        ctrl;
  logic             dec_unalloc;
  logic [1:0]       dec_size;
  logic [6:0]       dec_shamt;
  logic [VEC_W-1:0] kind_res [NKIND];
  logic [VEC_W-1:0] sel_result;

  shr_decode u_dec (
    .q_full (q_full),
    .immh   (immh),
    .immb   (immb),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  assign dec_unalloc = ctrl.unalloc;
  assign dec_size    = ctrl.size;
  assign dec_shamt   = ctrl.shamt;

  for (genvar g = 0; g < NKIND; g++) begin : g_kind
    localparam int LW = 8 << g;
    localparam int NL = VEC_W / LW;
    localparam int LSW = $clog2(LW) + 1;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      shr_lane #(.W(LW)) u_lane (
        .src         (src_vec[l*LW +: LW]),
        .dst         (dst_vec[l*LW +: LW]),
        .shamt       (dec_shamt[LSW-1:0]),
        .is_unsigned (is_unsigned),
        .do_round    (ctrl.rnd),
        .do_acc      (ctrl.acc),
        .res         (kind_res[g][l*LW +: LW])
      );
    end
  end

  always_comb begin
    sel_result = kind_res[dec_size];
    if (!q_full) sel_result[VEC_W-1:HALF_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      unalloc   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        unalloc <= dec_unalloc;
        if (!dec_unalloc) result <= sel_result;
      end
    end
  end
endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             q_full,
  input logic [3:0]       immh,
  input logic             dec_unalloc,
  input logic [1:0]       dec_size,
  input logic [6:0]       dec_shamt,
  input logic             out_valid,
  input logic             unalloc,
  input logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;

  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_unalloc) |-> (dec_shamt >= 7'd1 && dec_shamt <= (7'd8 << dec_size))); // R2

  AST_WIDE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && immh[3]) |-> (dec_size == 2'd3)); // R1

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R12

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !q_full && !dec_unalloc) |=> (result[VEC_W-1:HALF_W] == '0)); // R8

  AST_NARROW_WIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !q_full && immh[3]) |=> unalloc); // R9

  AST_ZERO_IMMH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && immh == 4'd0) |=> unalloc); // R10

  AST_HOLD_ON_UNALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_unalloc) |=> $stable(result)); // R9
endmodule

bind simd_rshift_acc shr_checker #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .q_full      (q_full),
  .immh        (immh),
  .dec_unalloc (dec_unalloc),
  .dec_size    (dec_size),
  .dec_shamt   (dec_shamt),
  .out_valid   (out_valid),
  .unalloc     (unalloc),
  .result      (result)
);

// File: tb/simd_rshift_acc_bench.sv
module simd_rshift_acc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         q_full = 1'b0;
  logic         is_unsigned = 1'b0;
  logic [3:0]   immh = 4'd0;
  logic [2:0]   immb = 3'd0;
  logic [4:0]   opcode = 5'd0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic         out_valid;
  logic         unalloc;
  logic [127:0] result;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [127:0] q_res [$];
  logic         q_un  [$];
  string        q_tag [$];
  logic [127:0] last_res = '0;

  always #4 clk = ~clk;

  simd_rshift_acc u_simd_rshift_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .q_full(q_full),
    .is_unsigned(is_unsigned), .immh(immh), .immb(immb), .opcode(opcode),
    .src_vec(src_vec), .dst_vec(dst_vec), .out_valid(out_valid),
    .unalloc(unalloc), .result(result)
  );

  function automatic logic [63:0] model_lane(input logic [63:0] s, input logic [63:0] d,
                                             input int w, input int sh, input bit u,
                                             input bit rnd, input bit acc);
    logic [63:0] m;
    logic [63:0] sv;
    logic signed [65:0] v;
    logic [63:0] r;
    m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sv = s & m;
    if (!u && sv[w-1]) v = {2'b11, sv | ~m};
    else               v = {2'b00, sv};
    if (rnd) v = v + (66'sd1 <<< (sh - 1));
    v = v >>> sh;
    r = v[63:0];
    if (acc) r = r + (d & m);
    return r & m;
  endfunction

  task automatic check(input string tag, input bit ok, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input bit q, input bit u, input logic [3:0] h,
                       input logic [2:0] b, input logic [4:0] op,
                       input logic [127:0] s, input logic [127:0] d);
    bit bad;
    int sz, w, sh, n;
    logic [127:0] exp;
    bad = (h == 4'd0) || (h[3] && !q) || !(op == 5'h00 || op == 5'h02 || op == 5'h04 || op == 5'h06);
    sz = h[3] ? 3 : h[2] ? 2 : h[1] ? 1 : 0;
    w  = 8 << sz;
    sh = 2 * w - int'({h, b});
    n  = (q ? 128 : 64) / w;
    exp = '0;
    if (bad) exp = last_res;
    else begin
      for (int i = 0; i < n; i++) begin
        logic [127:0] ts, td, tr;
        logic [63:0] lr;
        ts = s >> (i * w);
        td = d >> (i * w);
        lr = model_lane(ts[63:0], td[63:0], w, sh, u, op[2], op[1]);
        tr = {64'd0, lr};
        exp = exp | (tr << (i * w));
      end
      last_res = exp;
    end
    q_res.push_back(exp);
    q_un.push_back(bad);
    q_tag.push_back(tag);
    q_full = q; is_unsigned = u; immh = h; immb = b; opcode = op;
    src_vec = s; dst_vec = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (q_res.size() == 0) check("R12 spurious strobe", 1'b0, 128'd1, 128'd0);
        else begin
          logic [127:0] e;
          logic eu;
          string t;
          e = q_res.pop_front(); eu = q_un.pop_front(); t = q_tag.pop_front();
          check({t, " result"}, result == e, result, e);
          check({t, " flag"}, unalloc == eu, {127'd0, unalloc}, {127'd0, eu});
        end
      end else if (q_res.size() > 1)
        check("R12 missing strobe", 1'b0, 128'd0, 128'd1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset result", result == '0, result, '0);
    check("R12 reset flags", {out_valid, unalloc} == 2'b00, {126'd0, out_valid, unalloc}, '0);

    // R1/R3: plain shifts for each lane width, signed and unsigned
    apply("R1 R3 u8 sh3",  1, 1, 4'b0001, 3'd5, 5'h00, {16{8'hF4}}, '0);
    apply("R1 R3 s8 sh3",  1, 0, 4'b0001, 3'd5, 5'h00, {16{8'hF4}}, '0);
    apply("R1 R3 s16 sh4", 1, 0, 4'b0011, 3'd4, 5'h00, {8{16'h8F00}}, '0);
    apply("R1 R3 u32 sh7", 1, 1, 4'b0111, 3'd1, 5'h00, {4{32'hDEAD_BEEF}}, '0);
    apply("R1 R3 s64 sh9", 1, 0, 4'b1110, 3'd7, 5'h00, {2{64'h8123_4567_89AB_CDEF}}, '0);
    // R2: shift 1 and full width
    apply("R2 u16 sh1",  1, 1, 4'b0011, 3'd7, 5'h00, {8{16'hFFFF}}, '0);
    apply("R2 R6 u32 sh32", 1, 1, 4'b0100, 3'd0, 5'h00, {4{32'hFFFF_FFFF}}, '0);
    // R6: full-width shift
    apply("R6 s8 sh8",   1, 0, 4'b0001, 3'd0, 5'h00, {8{8'h80, 8'h7F}}, '0);
    apply("R6 s64 sh64", 1, 0, 4'b1000, 3'd0, 5'h00, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, '0);
    apply("R6 u64 sh64", 1, 1, 4'b1000, 3'd0, 5'h00, '1, '0);
    // R4: rounding carry out of top bit
    apply("R4 u8 round sh1", 1, 1, 4'b0001, 3'd7, 5'h04, {16{8'hFF}}, '0);
    apply("R4 u64 round sh1", 1, 1, 4'b1111, 3'd7, 5'h04, '1, '0);
    apply("R4 u64 round sh64", 1, 1, 4'b1000, 3'd0, 5'h04, {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF}, '0);
    // R5: signed rounding with sign extension
    apply("R5 s64 round sh64", 1, 0, 4'b1000, 3'd0, 5'h04, {64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, '0);
    apply("R5 s64 round sh1", 1, 0, 4'b1111, 3'd7, 5'h04, {64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFD}, '0);
    apply("R5 s8 round sh8", 1, 0, 4'b0001, 3'd0, 5'h04, {8{8'h80, 8'hC0}}, '0);
    // R7: accumulate with wrap
    apply("R7 u8 acc wrap", 1, 1, 4'b0001, 3'd7, 5'h02, {16{8'hFE}}, {16{8'hF0}});
    apply("R7 s32 rndacc", 1, 0, 4'b0111, 3'd0, 5'h06, {4{32'h8000_0001}}, {4{32'h7FFF_FFFF}});
    apply("R7 u64 rndacc", 1, 1, 4'b1000, 3'd0, 5'h06, '1, '1);
    // R8: half-width vectors
    apply("R8 q0 u16", 0, 1, 4'b0010, 3'd3, 5'h00, '1, '1);
    apply("R8 q0 s32 acc", 0, 0, 4'b0110, 3'd2, 5'h02, '1, '1);
    // R9, R10, R11: unallocated encodings hold the result
    apply("R9 q0 wide", 0, 1, 4'b1000, 3'd1, 5'h00, '1, '1);
    apply("R10 immh zero", 1, 1, 4'b0000, 3'd4, 5'h00, '1, '0);
    apply("R11 opcode 0x0a", 1, 1, 4'b0001, 3'd4, 5'h0A, '1, '0);
    apply("R11 opcode 0x01", 1, 0, 4'b1000, 3'd4, 5'h01, '1, '0);
    // R12: back-to-back random mix
    for (int k = 0; k < 300; k++) begin
      logic [4:0] op;
      logic [3:0] h;
      op = 5'($urandom_range(0, 3) * 2);
      if ($urandom_range(0, 15) == 0) op = 5'($urandom);
      h = 4'($urandom);
      apply("R12 random", 1'($urandom), 1'($urandom), h, 3'($urandom), op,
            {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
    end
    repeat (3) @(negedge clk);
    check("R12 drained", q_res.size() == 0, 128'(q_res.size()), '0);
    check("R12 idle strobe", out_valid == 1'b0, {127'd0, out_valid}, '0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule